// File: doc/BRIEF.md
# Serial-Controlled Eight-Switch Register Interface

This block is a serial-peripheral target that holds the open/closed state of eight independent single-pole switches. A host drives a serial clock, a data input and an active-low select, and the block returns read data on its serial output. All serial pins are brought into the system clock domain through a synchronizer, and the block acts on the detected edges. The system clock must run at least eight times faster than the serial clock.

A command is 16 bits, sent most significant bit first: a direction bit, a 7-bit register address and an 8-bit data field. In the default addressed mode, one whole command must fill the select window. With the burst flag set, several commands can follow each other inside one window. A fixed enter command switches the block into a cascade mode. In that mode it behaves as an 8-bit shift stage between its data input and data output, so several devices can be chained. Only the hardware reset brings it back.

Top module: `spi_sw_ctrl`

## Requirements
- R1: A synchronous active-high reset opens all switches (sw_en = 0x00), clears the burst flag and the cascade mode, and drives the serial output low.
- R2: Command bits are taken on rising serial-clock edges while select is low, MSB first. Bit 1 is the direction (1 = read, 0 = write), bits 2–8 are the address and bits 9–16 are the data.
- R3: A write to address 0x01 sets sw_en to the data byte, where bit i closes switch i. It takes effect after select rises.
- R4: When the burst flag is clear, a window that does not hold exactly 16 bits (fewer, more, or two commands) changes no register.
- R5: On a read, the serial output is low for cycles 1–8. For cycles 9–16 it carries the addressed register MSB first and changes only on falling serial-clock edges. The data bits of a read change nothing.
- R6: Address 0x02 bit 0 is the burst flag and reads back in bit 0, with the other bits reading 0. Other addresses read as 0x00 and ignore writes.
- R7: With the burst flag set, each command takes effect at its 16th bit. Several commands are accepted in one window, and a trailing partial command is dropped when select rises.
- R8: The command 0x2500 enters cascade mode from the next select window on. It does not change the switches.
- R9: In cascade mode the serial output repeats the data input delayed by eight serial-clock cycles, and is low for the first eight cycles of a window. When select rises, the last eight bits received load sw_en, with the earliest of them in bit 7.
- R10: Once in cascade mode, windows are never decoded as commands again until reset.
- R11: Serial-clock edges while select is high change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low select |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Serial data out of the block (registered) |
| sw_en | output | 8 | Switch-closed vector, one bit per switch |

## Verification
The assertions watch every cycle for these properties: the serial output moves only on a falling clock edge or a select edge, the cascade mode never drops while out of reset, a register changes only when its own write strobe is active, the bit counter stays frozen while select is high, and a non-burst window of the wrong length never produces a write. Only the bench scenarios can show that the values are right. These include the full sweep of switch patterns written and read back, the byte position of read data within the frame, burst windows that mix reads and writes, and the eight-cycle delay and final load in cascade mode.

// File: rtl/spi_sw_pkg.sv
package spi_sw_pkg;
  localparam int RW_BITS = 1;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int HDR_W   = RW_BITS + ADDR_W;
  localparam int CMD_W   = HDR_W + DATA_W;

  localparam logic [ADDR_W-1:0] ADDR_SWITCH = 7'h01;
  localparam logic [ADDR_W-1:0] ADDR_BURST  = 7'h02;
  localparam logic [CMD_W-1:0]  CASCADE_CMD = 16'h2500;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/spi_sw_sync.sv
module spi_sw_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[gi] <= RST_VAL;
          else     stg[gi] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[gi] <= RST_VAL;
          else     stg[gi] <= stg[gi-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_sw_regs.sv
module spi_sw_regs
  import spi_sw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] sw_q,
  output logic              burst_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q    <= '0;
      burst_q <= 1'b0;
    end else begin
      if (load_en)
        sw_q <= load_data;
      else if (wr_en && wr_addr == ADDR_SWITCH)
        sw_q <= wr_data;
      if (wr_en && wr_addr == ADDR_BURST)
        burst_q <= wr_data[0];
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_SWITCH: rd_data = sw_q;
      ADDR_BURST:  rd_data = {{(DATA_W-1){1'b0}}, burst_q};
      default:     rd_data = '0;
    endcase
  end

  // R1: reset clears the switch and burst state
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sw_q == '0 && !burst_q));

  // R3: the switch byte moves only on its write or a cascade load
  assert_sw_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !(wr_en && wr_addr == ADDR_SWITCH)) |=> $stable(sw_q));

  // R6: the burst flag moves only on a write to its address
  assert_burst_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == ADDR_BURST) |=> $stable(burst_q));
endmodule

// File: rtl/spi_sw_frame.sv
module spi_sw_frame
  import spi_sw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              csn_s,
  input  logic              burst_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              load_en,
  output logic [DATA_W-1:0] load_data,
  output logic              sdo
);
  localparam int              CNT_W   = $clog2(CMD_W) + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_CMD = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_LST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(HDR_W - 1);

  logic             sclk_d, csn_d;
  logic             rise, fall, cs_start, cs_end;
  logic [CNT_W-1:0] bit_cnt;
  logic [CMD_W-1:0] shreg, next_word, cword;
  logic [DATA_W-1:0] out_sh, dc_sh;
  logic             sdo_q;
  logic             cascade_q, win_cascade;
  logic             hdr_bit, last_bit, burst_commit, addr_commit, commit, is_cascade;
  cmd_t             cw;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  assign rise     = sclk_s & ~sclk_d & ~csn_s;
  assign fall     = ~sclk_s & sclk_d & ~csn_s;
  assign cs_start = ~csn_s & csn_d;
  assign cs_end   = csn_s & ~csn_d;

  assign next_word    = {shreg[CMD_W-2:0], sdi_s};
  assign hdr_bit      = rise && !win_cascade && bit_cnt == CNT_HDR;
  assign last_bit     = rise && !win_cascade && bit_cnt == CNT_LST;
  assign burst_commit = last_bit && burst_en;
  assign addr_commit  = cs_end && !win_cascade && bit_cnt == CNT_CMD;
  assign commit       = burst_commit || addr_commit;
  assign cword        = burst_commit ? next_word : shreg;
  assign cw           = cword;
  assign is_cascade   = cword == CASCADE_CMD;

  assign rd_addr   = next_word[ADDR_W-1:0];
  assign wr_en     = commit && !cw.rd && !is_cascade;
  assign wr_addr   = cw.addr;
  assign wr_data   = cw.data;
  assign load_en   = cs_end && win_cascade;
  assign load_data = dc_sh;
  assign sdo       = sdo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt     <= '0;
      shreg       <= '0;
      out_sh      <= '0;
      dc_sh       <= '0;
      sdo_q       <= 1'b0;
      cascade_q   <= 1'b0;
      win_cascade <= 1'b0;
    end else begin
      if (commit && is_cascade)
        cascade_q <= 1'b1;
      if (cs_start) begin
        bit_cnt     <= '0;
        win_cascade <= cascade_q;
        dc_sh       <= '0;
        out_sh      <= '0;
        sdo_q       <= 1'b0;
      end else if (cs_end) begin
        sdo_q <= 1'b0;
      end else begin
        if (rise) begin
          if (win_cascade) begin
            dc_sh <= {dc_sh[DATA_W-2:0], sdi_s};
          end else begin
            shreg <= next_word;
            if (burst_commit)
              bit_cnt <= '0;
            else if (bit_cnt != CNT_MAX)
              bit_cnt <= bit_cnt + 1'b1;
            if (hdr_bit)
              out_sh <= next_word[HDR_W-1] ? rd_data : '0;
          end
        end
        if (fall) begin
          if (win_cascade) begin
            sdo_q <= dc_sh[DATA_W-1];
          end else begin
            sdo_q  <= out_sh[DATA_W-1];
            out_sh <= {out_sh[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  // R1: reset leaves cascade mode
  assert_reset_mode_R1: assert property (@(posedge clk)
    rst |=> (!cascade_q && !sdo_q));

  // R5: serial output moves only on a falling clock or a select edge
  assert_sdo_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    !(fall || cs_start || cs_end) |=> $stable(sdo_q));

  // R10: cascade mode is never left without reset
  assert_cascade_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    cascade_q |=> cascade_q);

  // R11: no counting while select is high
  assert_idle_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> $stable(bit_cnt));

  // R4: a non-burst window of the wrong length writes nothing
  assert_bad_len_R4: assert property (@(posedge clk) disable iff (rst)
    (cs_end && !burst_en && bit_cnt != CNT_CMD) |-> !wr_en);
endmodule

// File: rtl/spi_sw_ctrl.sv
module spi_sw_ctrl
  import spi_sw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic [DATA_W-1:0] sw_en
);
  logic [2:0]        pins_s;
  logic              burst_q, wr_en, load_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data, load_data, sw_q;

  spi_sw_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({spi_csn, spi_sclk, spi_sdi}),
    .q  (pins_s)
  );

  spi_sw_frame u_frame (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (pins_s[1]),
    .sdi_s    (pins_s[0]),
    .csn_s    (pins_s[2]),
    .burst_en (burst_q),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .load_en  (load_en),
    .load_data(load_data),
    .sdo      (spi_sdo)
  );

  spi_sw_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .load_en  (load_en),
    .load_data(load_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .sw_q     (sw_q),
    .burst_q  (burst_q)
  );

  assign sw_en = sw_q;
endmodule

// File: tb/spi_sw_ctrl_tb.sv
`timescale 1ns/1ps
module spi_sw_ctrl_tb;
  localparam int HALF = 5;
  localparam int WD   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0;
  logic       csn = 1'b1;
  logic       sdi = 1'b0;
  logic       sdo;
  logic [7:0] sw;
  int         n_tests = 0;
  int         n_fail  = 0;
  bit         done    = 0;
  logic [63:0] got;

  always #2.5 clk = ~clk;

  spi_sw_ctrl u_dut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_csn(csn),
    .spi_sdi(sdi), .spi_sdo(sdo), .sw_en(sw)
  );

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one select window, bits sent from word[nbits-1] down; sdo sample before rise i lands in got[nbits-i]
  task automatic xfer(input logic [63:0] word, input int nbits, output logic [63:0] so);
    so  = '0;
    csn = 1'b0;
    wclk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi  = word[nbits-1-i];
      sclk = 1'b0;
      wclk(HALF);
      so   = {so[62:0], sdo};
      sclk = 1'b1;
      wclk(HALF);
    end
    sclk = 1'b0;
    wclk(HALF);
    csn = 1'b1;
    wclk(2*HALF);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    xfer({48'h0, 1'b0, a, d}, 16, got);
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] junk);
    xfer({48'h0, 1'b1, a, junk}, 16, got);
  endtask

  initial begin
    wclk(WD);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    wclk(4);
    rst = 1'b0;
    wclk(2);
    check("R1 reset switches", {24'h0, sw}, 32'h0);
    check("R1 reset sdo", {31'h0, sdo}, 32'h0);

    // R3 R5 R2: every switch pattern written then read back
    for (int v = 0; v < 256; v++) begin
      wr(7'h01, 8'(v));
      check("R3 write switches", {24'h0, sw}, v);
      rd(7'h01, ~8'(v));
      check("R5 read frame", got[31:0], {24'h0, 8'(v)});
      check("R5 read data bits ignored", {24'h0, sw}, v);
    end

    // R4: wrong-length windows
    xfer({48'h0, 16'h0112} >> 1, 15, got);
    check("R4 short window", {24'h0, sw}, 32'hFF);
    xfer({47'h0, 16'h0112, 1'b0}, 17, got);
    check("R4 long window", {24'h0, sw}, 32'hFF);
    xfer({32'h0, 16'h0112, 16'h0134}, 32, got);
    check("R4 two commands no burst", {24'h0, sw}, 32'hFF);

    // R11: clocking with select high
    for (int i = 0; i < 20; i++) begin
      sdi  = i[0];
      sclk = ~sclk;
      wclk(HALF);
    end
    sclk = 1'b0;
    wclk(HALF);
    check("R11 idle clocks", {24'h0, sw}, 32'hFF);
    rd(7'h01, 8'h00);
    check("R11 readback after idle", got[31:0], 32'hFF);

    // R6: unmapped and burst register
    wr(7'h05, 8'hAA);
    rd(7'h05, 8'h00);
    check("R6 unmapped reads zero", got[31:0], 32'h0);
    check("R6 unmapped write ignored", {24'h0, sw}, 32'hFF);
    rd(7'h02, 8'h00);
    check("R6 burst flag clear", got[31:0], 32'h0);
    wr(7'h02, 8'hFF);
    rd(7'h02, 8'h00);
    check("R6 burst flag set", got[31:0], 32'h1);

    // R7: three commands and a partial in one window
    xfer({8'h0, 16'h01A5, 16'h8100, 16'h013C, 8'h01}, 56, got);
    check("R7 burst read in window", {24'h0, got[31:24]}, 32'hA5);
    check("R7 burst final switches", {24'h0, sw}, 32'h3C);
    wr(7'h02, 8'h00);
    rd(7'h02, 8'h00);
    check("R7 burst cleared", got[31:0], 32'h0);
    wr(7'h01, 8'h81);

    // R8: enter cascade
    xfer({48'h0, 16'h2500}, 16, got);
    check("R8 enter leaves switches", {24'h0, sw}, 32'h81);

    // R9: cascade shifting
    xfer({40'h0, 24'hC35A96}, 24, got);
    check("R9 cascade sdo delay", got[31:0], 32'h00C35A);
    check("R9 cascade load", {24'h0, sw}, 32'h96);

    // R10: commands no longer decoded
    xfer({48'h0, 16'h0200}, 16, got);
    check("R10 write frame loads switches", {24'h0, sw}, 32'h00);
    xfer({48'h0, 16'h8101}, 16, got);
    check("R10 read frame loads switches", {24'h0, sw}, 32'h01);
    check("R10 read frame echoes", got[31:0], 32'h0081);

    // R1: reset leaves cascade mode
    rst = 1'b1;
    wclk(3);
    rst = 1'b0;
    wclk(2);
    check("R1 reset after cascade", {24'h0, sw}, 32'h0);
    check("R1 reset sdo low", {31'h0, sdo}, 32'h0);
    wr(7'h01, 8'h42);
    check("R1 addressed mode restored", {24'h0, sw}, 32'h42);
    rd(7'h01, 8'h00);
    check("R1 read after reset", got[31:0], 32'h42);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule